// File: doc/BRIEF.md
# Two-Tone Phase-Accumulating Synthesizer with I/Q Amplitude Control

This block is a direct digital synthesis core. A 32-bit phase accumulator advances every clock by one of two stored tuning words, chosen per cycle by a one-bit select input. Loading the two words with a mark and a space frequency and driving the select input with a serial bit stream gives binary frequency shift keying with phase-continuous switching.

The top bits of the accumulated phase, offset by a programmable phase word, address a computed sine/cosine generator. The cosine is scaled by a signed I word and the sine by a signed Q word. The two scaled values are summed and saturated into a signed 10-bit sample for an external DAC. A simple write port loads all control words while the core runs. The I and Q words are first built up in a 32-bit staging word over several writes. A single command write then moves both into the active pair in the same clock, so the amplitude never passes through a half-updated state. Holding Q at zero and putting a carrier level plus an audio sample into I gives ordinary AM. A zero-centred I word gives suppressed-carrier modulation.

Top module: `dds_fsk_iq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator, both tuning words, the phase offset, the staging word, the I and Q words and all pipeline registers, so `sample_out` reads 0 after reset.
- R2: A write (`wr_en` high at an edge) to address 0/1 loads bits [15:0]/[31:16] of tuning word 0, to address 2/3 the same halves of tuning word 1, and to address 4 loads the 12-bit phase offset from `wr_data[11:0]`; the new value is used from the next edge on, while the core keeps running.
- R3: At every edge the accumulator adds tuning word 1 when `fsel` is 1 and tuning word 0 when `fsel` is 0, modulo 2^32, using the word values held before that edge.
- R4: The phase address, registered one edge after the accumulator, is accumulator bits [31:20] plus the phase offset, modulo 4096.
- R5: For a 12-bit address a, the wave value is sign a[11] with magnitude min(511, floor(x*(2048-x)/2048)), where x = a[10:0]; the sine uses a, the cosine uses a+1024 modulo 4096; both are registered one edge after the phase address.
- R6: The I and Q words are signed two's complement; the sample is floor(cos*I/512) + floor(sin*Q/512), saturated to [-512, 511], and is registered at the edge after the wave values, using the I/Q words held before that edge.
- R7: A write to address 5 shifts the 32-bit staging word left by 16 and inserts `wr_data[15:0]`; a write to address 7 shifts it left by 8 and inserts `wr_data[7:0]`, so the earliest write ends up in the most significant part.
- R8: Writes to the staging word alone change neither the I/Q words nor `sample_out`.
- R9: A write to address 6 whose `wr_data[15:12]` equals 4'hB loads I from staging bits [25:16] and Q from staging bits [9:0] at the same edge; any other value written to address 6 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| fsel | input | 1 | Tuning word select, 0 = word 0, 1 = word 1 |
| sample_out | output | 10 | Signed output sample for the DAC |

## Verification
The hardest cases to reach are the saturation corners and the exact moment a staged I/Q pair takes effect. Both need the phase held at a known address while specific amplitude words are committed. The bench sets both tuning words to zero so the accumulator stays put. It then uses the phase offset alone to park the address at points where the sine and cosine take known values, and commits extreme I/Q pairs there. It also shows that staging writes and control writes with the wrong command nibble leave the output alone. After that it turns to random writes, random commit nibbles and a per-cycle random select, checked against a cycle model.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Write port address map
    typedef enum logic [2:0] {
        ADR_TW0_LO  = 3'd0,
        ADR_TW0_HI  = 3'd1,
        ADR_TW1_LO  = 3'd2,
        ADR_TW1_HI  = 3'd3,
        ADR_POFF    = 3'd4,
        ADR_STAGE16 = 3'd5,
        ADR_CMD     = 3'd6,
        ADR_STAGE8  = 3'd7
    } bus_addr_e;

    localparam logic [3:0] CMD_COMMIT = 4'hB;

endpackage

// File: rtl/dds_ctrl_regs.sv
module dds_ctrl_regs
    import dds_pkg::*;
#(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 12,
    parameter int AMP_W   = 10,
    parameter int BUS_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [BUS_W-1:0]         wr_data,
    output logic [FREQ_W-1:0]        tw0,
    output logic [FREQ_W-1:0]        tw1,
    output logic [PHASE_W-1:0]       poff,
    output logic [2*BUS_W-1:0]       stage,
    output logic signed [AMP_W-1:0]  i_word,
    output logic signed [AMP_W-1:0]  q_word
);
    localparam int STG_W = 2 * BUS_W;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [FREQ_W-1:0]  tw0;
        logic [FREQ_W-1:0]  tw1;
        logic [PHASE_W-1:0] poff;
        logic [STG_W-1:0]   stage;
        logic [AMP_W-1:0]   i;
        logic [AMP_W-1:0]   q;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (bus_addr_e'(wr_addr))
                ADR_TW0_LO:  r_d.tw0[BUS_W-1:0]      = wr_data;
                ADR_TW0_HI:  r_d.tw0[FREQ_W-1:BUS_W] = wr_data[FREQ_W-BUS_W-1:0];
                ADR_TW1_LO:  r_d.tw1[BUS_W-1:0]      = wr_data;
                ADR_TW1_HI:  r_d.tw1[FREQ_W-1:BUS_W] = wr_data[FREQ_W-BUS_W-1:0];
                ADR_POFF:    r_d.poff                = wr_data[PHASE_W-1:0];
                ADR_STAGE16: r_d.stage = {r_q.stage[STG_W-BUS_W-1:0], wr_data};
                ADR_STAGE8:  r_d.stage = {r_q.stage[STG_W-BYTE_W-1:0], wr_data[BYTE_W-1:0]};
                ADR_CMD: begin
                    if (wr_data[BUS_W-1 -: 4] == CMD_COMMIT) begin
                        r_d.i = r_q.stage[BUS_W +: AMP_W];
                        r_d.q = r_q.stage[0 +: AMP_W];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign tw0    = r_q.tw0;
    assign tw1    = r_q.tw1;
    assign poff   = r_q.poff;
    assign stage  = r_q.stage;
    assign i_word = $signed(r_q.i);
    assign q_word = $signed(r_q.q);

endmodule

// File: rtl/dds_phase.sv
module dds_phase #(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fsel,
    input  logic [FREQ_W-1:0]  tw0,
    input  logic [FREQ_W-1:0]  tw1,
    input  logic [PHASE_W-1:0] poff,
    output logic [FREQ_W-1:0]  acc,
    output logic [PHASE_W-1:0] ph_addr
);
    typedef struct packed {
        logic [FREQ_W-1:0]  acc;
        logic [PHASE_W-1:0] ph;
    } phase_t;

    phase_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.acc = s_q.acc + (fsel ? tw1 : tw0);
        s_d.ph  = s_q.acc[FREQ_W-1 -: PHASE_W] + poff;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign acc     = s_q.acc;
    assign ph_addr = s_q.ph;

endmodule

// File: rtl/dds_wave.sv
module dds_wave #(
    parameter int PHASE_W  = 12,
    parameter int AMP_W    = 10,
    parameter int PH_SHIFT = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PHASE_W-1:0]      ph_addr,
    output logic signed [AMP_W-1:0] wave
);
    localparam int X_W    = PHASE_W - 1;
    localparam int PROD_W = 2 * X_W + 1;
    localparam int HALF   = 2 ** X_W;
    localparam int SHIFT  = 2 * X_W - AMP_W - 1;
    localparam int MAXA   = 2 ** (AMP_W - 1) - 1;

    typedef struct packed {
        logic [AMP_W-1:0] w;
    } wave_t;

    wave_t w_d, w_q;

    logic [PHASE_W-1:0] a;
    logic [X_W-1:0]     x;
    logic [X_W:0]       span;
    logic [PROD_W-1:0]  prod;
    logic [PROD_W-1:0]  mag_full;
    logic [AMP_W-1:0]   mag;

    always_comb begin
        a        = ph_addr + PHASE_W'(PH_SHIFT);
        x        = a[X_W-1:0];
        span     = (X_W+1)'(HALF) - {1'b0, x};
        prod     = PROD_W'(x) * PROD_W'(span);
        mag_full = prod >> SHIFT;
        if (mag_full > PROD_W'(MAXA)) mag = AMP_W'(MAXA);
        else                          mag = mag_full[AMP_W-1:0];
        w_d.w = a[PHASE_W-1] ? (~mag + 1'b1) : mag;
    end

    always_ff @(posedge clk) begin
        if (rst) w_q <= '0;
        else     w_q <= w_d;
    end

    assign wave = $signed(w_q.w);

endmodule

// File: rtl/dds_mixer.sv
module dds_mixer #(
    parameter int AMP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [AMP_W-1:0] cos_in,
    input  logic signed [AMP_W-1:0] sin_in,
    input  logic signed [AMP_W-1:0] i_word,
    input  logic signed [AMP_W-1:0] q_word,
    output logic signed [AMP_W-1:0] sample
);
    localparam int P_W  = 2 * AMP_W;
    localparam int T_W  = AMP_W + 1;
    localparam int S_W  = AMP_W + 2;
    localparam logic signed [S_W-1:0] MAXV = S_W'(2 ** (AMP_W - 1) - 1);
    localparam logic signed [S_W-1:0] MINV = -S_W'(2 ** (AMP_W - 1));

    typedef struct packed {
        logic [AMP_W-1:0] smp;
    } mix_t;

    mix_t m_d, m_q;

    logic signed [P_W-1:0] p_i, p_q;
    logic signed [T_W-1:0] t_i, t_q;
    logic signed [S_W-1:0] sum;

    always_comb begin
        p_i = cos_in * i_word;
        p_q = sin_in * q_word;
        t_i = $signed(p_i[P_W-1 -: T_W]);
        t_q = $signed(p_q[P_W-1 -: T_W]);
        sum = S_W'(t_i) + S_W'(t_q);
        m_d = m_q;
        if (sum > MAXV)      m_d.smp = MAXV[AMP_W-1:0];
        else if (sum < MINV) m_d.smp = MINV[AMP_W-1:0];
        else                 m_d.smp = sum[AMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) m_q <= '0;
        else     m_q <= m_d;
    end

    assign sample = $signed(m_q.smp);

endmodule

// File: rtl/dds_fsk_iq.sv
module dds_fsk_iq #(
    parameter int FREQ_W  = 32,
    parameter int PHASE_W = 12,
    parameter int AMP_W   = 10,
    parameter int BUS_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [2:0]              wr_addr,
    input  logic [BUS_W-1:0]        wr_data,
    input  logic                    fsel,
    output logic signed [AMP_W-1:0] sample_out
);
    localparam int NCH     = 2;
    localparam int QUARTER = 2 ** (PHASE_W - 2);

    logic [FREQ_W-1:0]       tw0_w, tw1_w, acc_w;
    logic [PHASE_W-1:0]      poff_w, ph_w;
    logic [2*BUS_W-1:0]      stage_w;
    logic signed [AMP_W-1:0] i_w, q_w;
    logic signed [AMP_W-1:0] wave_w [NCH];

    dds_ctrl_regs #(
        .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .BUS_W(BUS_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tw0(tw0_w), .tw1(tw1_w), .poff(poff_w), .stage(stage_w),
        .i_word(i_w), .q_word(q_w)
    );

    dds_phase #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_phase (
        .clk(clk), .rst(rst), .fsel(fsel), .tw0(tw0_w), .tw1(tw1_w),
        .poff(poff_w), .acc(acc_w), .ph_addr(ph_w)
    );

    // channel 0: sine, channel 1: cosine (quarter-turn ahead)
    for (genvar c = 0; c < NCH; c++) begin : g_wave
        dds_wave #(
            .PHASE_W(PHASE_W), .AMP_W(AMP_W), .PH_SHIFT(c * QUARTER)
        ) u_wave (
            .clk(clk), .rst(rst), .ph_addr(ph_w), .wave(wave_w[c])
        );
    end

    dds_mixer #(.AMP_W(AMP_W)) u_mix (
        .clk(clk), .rst(rst), .cos_in(wave_w[1]), .sin_in(wave_w[0]),
        .i_word(i_w), .q_word(q_w), .sample(sample_out)
    );

endmodule

// File: rtl/dds_fsk_iq_checker.sv
module dds_fsk_iq_checker (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [15:0]       wr_data,
    input logic              fsel,
    input logic signed [9:0] sample_out,
    input logic [31:0]       acc,
    input logic [31:0]       tw0,
    input logic [31:0]       tw1,
    input logic [31:0]       stage,
    input logic signed [9:0] i_word,
    input logic signed [9:0] q_word
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc == 32'd0 && sample_out == 10'sd0 && i_word == 10'sd0));

    assert_acc_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc == $past(acc) + ($past(fsel) ? $past(tw1) : $past(tw0)));

    assert_stage_only_R8: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && (wr_addr == 3'd5 || wr_addr == 3'd7))
        |-> (i_word == $past(i_word) && q_word == $past(q_word)));

    assert_commit_R9: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == 3'd6 && wr_data[15:12] == 4'hB)
        |-> (i_word == $signed($past(stage[25:16])) && q_word == $signed($past(stage[9:0]))));

    assert_bad_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == 3'd6 && wr_data[15:12] != 4'hB)
        |-> (i_word == $past(i_word) && q_word == $past(q_word)));

    assert_zero_iq_R6: assert property (@(posedge clk) disable iff (rst)
        (i_word == 10'sd0 && q_word == 10'sd0) |=> sample_out == 10'sd0);

endmodule

bind dds_fsk_iq dds_fsk_iq_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel(fsel), .sample_out(sample_out), .acc(acc_w), .tw0(tw0_w), .tw1(tw1_w),
    .stage(stage_w), .i_word(i_w), .q_word(q_w)
);

// File: tb/dds_fsk_iq_test.sv
module dds_fsk_iq_test;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic              fsel = 1'b0;
    logic signed [9:0] sample_out;

    int  checks = 0;
    int  errors = 0;
    bit  model_on = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dds_fsk_iq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fsel(fsel), .sample_out(sample_out)
    );

    // ---------------- reference functions from the requirements
    function automatic int f_wave(input logic [11:0] a);   // R5
        int x, mag;
        x   = int'(a[10:0]);
        mag = (x * (2048 - x)) / 2048;
        if (mag > 511) mag = 511;
        return a[11] ? -mag : mag;
    endfunction

    function automatic int f_mix(input int c, input int s, input int i, input int q); // R6
        int t;
        t = ((c * i) >>> 9) + ((s * q) >>> 9);
        if (t > 511)  t = 511;
        if (t < -512) t = -512;
        return t;
    endfunction

    function automatic int sx10(input logic [9:0] v);
        return int'($signed(v));
    endfunction

    // ---------------- cycle model
    logic [31:0] m_tw0, m_tw1, m_acc, m_stg;
    logic [11:0] m_poff, m_ph;
    int          m_sin, m_cos, m_out, m_i, m_q;

    always @(posedge clk) begin
        if (rst) begin
            m_tw0 <= '0; m_tw1 <= '0; m_acc <= '0; m_stg <= '0;
            m_poff <= '0; m_ph <= '0;
            m_sin <= 0; m_cos <= 0; m_out <= 0; m_i <= 0; m_q <= 0;
        end else begin
            m_out <= f_mix(m_cos, m_sin, m_i, m_q);
            m_sin <= f_wave(m_ph);
            m_cos <= f_wave(m_ph + 12'd1024);
            m_ph  <= m_acc[31:20] + m_poff;
            m_acc <= m_acc + (fsel ? m_tw1 : m_tw0);
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_tw0[15:0]  <= wr_data;
                    3'd1: m_tw0[31:16] <= wr_data;
                    3'd2: m_tw1[15:0]  <= wr_data;
                    3'd3: m_tw1[31:16] <= wr_data;
                    3'd4: m_poff <= wr_data[11:0];
                    3'd5: m_stg  <= {m_stg[15:0], wr_data};
                    3'd7: m_stg  <= {m_stg[23:0], wr_data[7:0]};
                    default: if (wr_data[15:12] == 4'hB) begin
                        m_i <= sx10(m_stg[25:16]);
                        m_q <= sx10(m_stg[9:0]);
                    end
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the cycle model (R2 R3 R4 R6)
    always @(negedge clk) begin
        if (model_on && !rst)
            check(int'(sample_out) == m_out, "R3 model", int'(sample_out), m_out);
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_iq(input logic [9:0] i, input logic [9:0] q);
        wr(3'd5, {6'd0, i});
        wr(3'd5, {6'd0, q});
        wr(3'd6, 16'hB000);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_on = 1'b1;
        @(negedge clk);
        check(sample_out == 10'sd0, "R1 reset", int'(sample_out), 0);

        // R5: phase 0, cosine peak 511 scaled by I=511
        set_iq(10'd511, 10'd0);
        settle();
        check(int'(sample_out) == 510, "R5 cos peak", int'(sample_out), 510);

        // R8: staging writes alone leave output unchanged
        wr(3'd5, 16'h0000);
        wr(3'd7, 16'h0000);
        settle();
        check(int'(sample_out) == 510, "R8 stage only", int'(sample_out), 510);

        // R9: wrong command nibble ignored, then real commit of zero pair
        wr(3'd6, 16'hA000);
        settle();
        check(int'(sample_out) == 510, "R9 bad cmd", int'(sample_out), 510);
        wr(3'd6, 16'hB123);
        settle();
        check(int'(sample_out) == 0, "R9 commit", int'(sample_out), 0);

        // R4: offset 2048 puts cosine at its negative peak
        wr(3'd4, 16'd2048);
        set_iq(10'd511, 10'd0);
        settle();
        check(int'(sample_out) == -511, "R4 offset", int'(sample_out), -511);

        // R6: saturation both ways at offset 512
        wr(3'd4, 16'd512);
        set_iq(10'd511, 10'd511);
        settle();
        check(int'(sample_out) == 511, "R6 sat high", int'(sample_out), 511);
        set_iq(10'h200, 10'h200);
        settle();
        check(int'(sample_out) == -512, "R6 sat low", int'(sample_out), -512);

        // R7: byte-wise staging, earliest byte most significant
        wr(3'd4, 16'd0);
        wr(3'd7, 16'h0001);
        wr(3'd7, 16'h00FF);
        wr(3'd7, 16'h0000);
        wr(3'd7, 16'h0000);
        wr(3'd6, 16'hB000);
        settle();
        check(int'(sample_out) == 510, "R7 byte stage", int'(sample_out), 510);

        // R2 R3: FSK between two running tuning words
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0010);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0030);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            fsel = ((k / 7) % 2) == 1;
        end
        fsel = 1'b0;

        // R1 again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(sample_out == 10'sd0, "R1 rerun", int'(sample_out), 0);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            fsel = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 3'($urandom_range(0, 7));
                wr_data = 16'($urandom);
                if (wr_addr == 3'd6 && $urandom_range(0, 1) == 1) wr_data[15:12] = 4'hB;
                if ((wr_addr == 3'd1 || wr_addr == 3'd3) && $urandom_range(0, 1) == 1)
                    wr_data = 16'($urandom_range(0, 255));
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule